// File: doc/BRIEF.md
# Swipe Sensor Frame Readout Controller

This block drives a swipe-style fingerprint sensor that returns two 4-bit pixels per clock pulse. It generates the sensor's reset, its pixel clock (derived from the system clock by a parameterized divider) and its active-low output enable. On a start request it runs the power-up sequence and then reads frames without a break. The sequence is a reset pulse, a few pipeline-flush pulses, and one whole frame whose data is thrown away because its integration time is wrong.

Each frame has `COLS` real columns followed by one dummy column. Every column is `ROWS` pixels tall, so each column takes `ROWS/2` bytes. Every byte is captured in the half period after the pixel clock rises, just before it falls. The byte is split into an even pixel and an odd pixel. The even pixel leaves first on a valid/ready stream that marks the start and end of each frame. Bytes of the dummy column are clocked out of the sensor but not forwarded.

Back-pressure rules: `pix_data`, `pix_sof` and `pix_eof` are meaningful only while `pix_valid` is high. Once raised, `pix_valid` and the data stay unchanged until a cycle with `pix_ready` high. A new pixel-clock pulse starts only when the held byte has been fully accepted. A slow consumer therefore stretches the low phase of the pixel clock, and no pixel is lost or repeated. A stop request takes effect at the next frame boundary.

Top module: `swr_readout`

## Requirements
- R1: After system reset, `sen_rst` is low, `sen_oe_n` is high, `sen_clk` is low and `pix_valid` is low.
- R2: A start pulse in idle raises `sen_rst` for `RST_CYC` cycles while `sen_clk` stays low and `sen_oe_n` stays high. After `sen_rst` falls, exactly `FLUSH + (COLS+1)*ROWS/2` clock pulses occur before `sen_oe_n` falls.
- R3: Every `sen_clk` pulse is high for exactly `DIV_HALF` system cycles, and every low phase lasts at least `DIV_HALF` cycles.
- R4: `sen_oe_n` falls only after `sen_clk` has been low for more than `QUIET` system cycles. `sen_rst` is never high while `sen_oe_n` is low.
- R5: Byte k of a frame (k counted from 0, pixel-clock pulse order after the flush pulses) yields two stream pixels: first the even nibble `sen_even`, then the odd nibble `sen_odd`, each with its value as driven by the sensor during that pulse.
- R6: The last `ROWS/2` bytes of every frame (the dummy column) produce no stream pixels, so each frame carries exactly `COLS*ROWS` pixels.
- R7: `pix_sof` is high only on the even pixel of byte 0, and `pix_eof` only on the odd pixel of byte `COLS*ROWS/2 - 1`. Each appears once per frame.
- R8: While `pix_valid` is high and `pix_ready` is low, the next cycle keeps `pix_valid` high with unchanged `pix_data`, `pix_sof` and `pix_eof`. No pixel is lost or duplicated under any ready pattern.
- R9: Frames follow one another without a new sensor reset. A start pulse while acquisition runs has no effect.
- R10: A stop pulse ends acquisition at the end of the frame in progress (or at the end of the discarded frame during start-up). The block then returns to idle with `sen_rst` low, `sen_oe_n` high and no clock pulses. A stop pulse in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin acquisition from idle |
| stop | input | 1 | One-cycle request to end acquisition at the next frame boundary |
| sen_even | input | NIB | Even-pixel nibble from the sensor |
| sen_odd | input | NIB | Odd-pixel nibble from the sensor |
| sen_clk | output | 1 | Pixel clock to the sensor |
| sen_rst | output | 1 | Active-high sensor reset |
| sen_oe_n | output | 1 | Active-low sensor output enable |
| pix_valid | output | 1 | Stream pixel valid |
| pix_ready | input | 1 | Stream consumer ready |
| pix_data | output | NIB | Stream pixel value |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eof | output | 1 | Last pixel of a frame |

## Verification
A behavioural sensor model counts pixel-clock rising edges from its reset, so each byte's value encodes its frame and byte index. Any misalignment in the start-up count, any dropped or repeated pulse, or any forwarded dummy byte then shows up as a wrong value or a misplaced frame marker. The stream is read under four ready patterns: always ready, alternating, one cycle in five, and long stalls. Always-ready checks the back-to-back rate. The sparse and long-stall patterns check that stretching the clock low phase keeps the sensor pipeline aligned. The flow covers a stop pulse in idle, a start pulse during reads, a stop pulse in mid-frame and a stop pulse during start-up. Together these separate the frame-boundary stop from an immediate stop and confirm that a restart re-runs the full sequence.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTHI,
    ST_FLUSH,
    ST_SKIP,
    ST_OEWAIT,
    ST_READ
  } swr_state_e;
endpackage

// File: rtl/swr_pclk_gen.sv
// One pixel-clock pulse per accepted launch: high DIV_HALF cycles, then low
// DIV_HALF cycles. Back-to-back launches give a steady 2*DIV_HALF period.
module swr_pclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic pclk,
  output logic sample,
  output logic done
);
  localparam int PW = $clog2(2 * DIV_HALF);
  localparam logic [PW-1:0] LAST_HI = PW'(DIV_HALF - 1);
  localparam logic [PW-1:0] LAST    = PW'(2 * DIV_HALF - 1);

  logic          active;
  logic [PW-1:0] ph;
  logic          hi_q;
  logic          launch;

  assign done   = active && (ph == LAST);
  assign sample = active && (ph == LAST_HI);
  assign launch = go && (!active || done);
  assign pclk   = hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      hi_q   <= 1'b0;
    end else if (launch) begin
      active <= 1'b1;
      ph     <= '0;
      hi_q   <= 1'b1;
    end else if (active) begin
      if (ph == LAST_HI) hi_q <= 1'b0;
      if (done) begin
        active <= 1'b0;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swr_seq.sv
// Start-up and acquisition sequencer: reset pulse, flush pulses, discarded
// frame, quiet wait before output enable, then continuous frame reads.
module swr_seq
  import swr_pkg::*;
#(
  parameter int FLUSH   = 4,
  parameter int BPF     = 1124,
  parameter int RST_CYC = 8,
  parameter int QUIET   = 3,
  localparam int CW = $clog2(BPF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          pclk,
  input  logic          done,
  input  logic          can_take,
  output logic          go,
  output logic          sen_rst,
  output logic          oe_n,
  output logic          rd,
  output logic [CW-1:0] cnt
);
  localparam int TW = $clog2(RST_CYC + 1);
  localparam int QW = $clog2(QUIET + 1);
  localparam logic [QW-1:0] QLIM = QW'(QUIET);

  swr_state_e    state;
  logic [TW-1:0] tmr;
  logic [QW-1:0] sf;
  logic          stop_pend;
  logic          oe_q;
  logic          at_end;

  assign at_end  = done && (cnt == CW'(BPF - 1));
  assign sen_rst = (state == ST_RSTHI);
  assign oe_n    = oe_q;
  assign rd      = (state == ST_READ);

  always_comb begin
    unique case (state)
      ST_FLUSH: go = 1'b1;
      ST_SKIP:  go = !at_end;
      ST_READ:  go = can_take && !(at_end && stop_pend);
      default:  go = 1'b0;
    endcase
  end

  // low-phase run length since the most recent clock fall, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)         sf <= '0;
    else if (pclk)      sf <= '0;
    else if (sf != QLIM) sf <= sf + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 stop_pend <= 1'b0;
    else if (state == ST_IDLE)  stop_pend <= 1'b0;
    else if (stop)              stop_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tmr   <= '0;
      cnt   <= '0;
      oe_q  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RSTHI;
          tmr   <= '0;
        end
        ST_RSTHI: begin
          if (tmr == TW'(RST_CYC - 1)) begin
            state <= ST_FLUSH;
            cnt   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_FLUSH: if (done) begin
          if (cnt == CW'(FLUSH - 1)) begin
            state <= ST_SKIP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SKIP: if (done) begin
          if (at_end) begin
            cnt   <= '0;
            state <= stop_pend ? ST_IDLE : ST_OEWAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OEWAIT: if (sf >= QLIM) begin
          oe_q  <= 1'b0;
          state <= ST_READ;
          cnt   <= '0;
        end
        ST_READ: if (done) begin
          if (at_end) begin
            cnt <= '0;
            if (stop_pend) begin
              state <= ST_IDLE;
              oe_q  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swr_unpack.sv
// Holds one captured byte and releases it as two stream pixels, even first.
// Dummy-column bytes are not loaded.
module swr_unpack #(
  parameter int NIB  = 4,
  parameter int COLS = 280,
  parameter int BPC  = 4,
  parameter int CW   = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic [CW-1:0]  cnt,
  input  logic [NIB-1:0] in_even,
  input  logic [NIB-1:0] in_odd,
  input  logic           ready,
  output logic           valid,
  output logic [NIB-1:0] data,
  output logic           sof,
  output logic           eof,
  output logic           can_take
);
  localparam int REAL = COLS * BPC;

  logic           full;
  logic           sel_odd;
  logic [NIB-1:0] h_even;
  logic [NIB-1:0] h_odd;
  logic           h_first;
  logic           h_last;
  logic           keep;
  logic           fire;

  assign keep     = (cnt < CW'(REAL));
  assign fire     = full && ready;
  assign can_take = !full || (fire && sel_odd);

  assign valid = full;
  assign data  = sel_odd ? h_odd : h_even;
  assign sof   = full && h_first && !sel_odd;
  assign eof   = full && h_last && sel_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      sel_odd <= 1'b0;
      h_even  <= '0;
      h_odd   <= '0;
      h_first <= 1'b0;
      h_last  <= 1'b0;
    end else if (cap && keep) begin
      full    <= 1'b1;
      sel_odd <= 1'b0;
      h_even  <= in_even;
      h_odd   <= in_odd;
      h_first <= (cnt == '0);
      h_last  <= (cnt == CW'(REAL - 1));
    end else if (fire) begin
      if (sel_odd) begin
        full    <= 1'b0;
        sel_odd <= 1'b0;
      end else begin
        sel_odd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swr_readout.sv
module swr_readout #(
  parameter int COLS     = 280,
  parameter int ROWS     = 8,
  parameter int NIB      = 4,
  parameter int DIV_HALF = 4,
  parameter int QUIET    = 3,
  parameter int FLUSH    = 4,
  parameter int RST_CYC  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic [NIB-1:0] sen_even,
  input  logic [NIB-1:0] sen_odd,
  output logic           sen_clk,
  output logic           sen_rst,
  output logic           sen_oe_n,
  output logic           pix_valid,
  input  logic           pix_ready,
  output logic [NIB-1:0] pix_data,
  output logic           pix_sof,
  output logic           pix_eof
);
  localparam int BPC = ROWS / 2;
  localparam int BPF = (COLS + 1) * BPC;
  localparam int CW  = $clog2(BPF);

  logic          go;
  logic          sample;
  logic          done;
  logic          rd;
  logic          can_take;
  logic [CW-1:0] cnt;

  swr_pclk_gen #(.DIV_HALF(DIV_HALF)) u_pclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .pclk   (sen_clk),
    .sample (sample),
    .done   (done)
  );

  swr_seq #(
    .FLUSH   (FLUSH),
    .BPF     (BPF),
    .RST_CYC (RST_CYC),
    .QUIET   (QUIET)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .pclk     (sen_clk),
    .done     (done),
    .can_take (can_take),
    .go       (go),
    .sen_rst  (sen_rst),
    .oe_n     (sen_oe_n),
    .rd       (rd),
    .cnt      (cnt)
  );

  swr_unpack #(
    .NIB  (NIB),
    .COLS (COLS),
    .BPC  (BPC),
    .CW   (CW)
  ) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (sample && rd),
    .cnt      (cnt),
    .in_even  (sen_even),
    .in_odd   (sen_odd),
    .ready    (pix_ready),
    .valid    (pix_valid),
    .data     (pix_data),
    .sof      (pix_sof),
    .eof      (pix_eof),
    .can_take (can_take)
  );
endmodule

// File: rtl/swr_readout_chk.sv
module swr_readout_chk #(
  parameter int NIB      = 4,
  parameter int DIV_HALF = 4,
  parameter int QUIET    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sen_clk,
  input logic           sen_rst,
  input logic           sen_oe_n,
  input logic           pix_valid,
  input logic           pix_ready,
  input logic [NIB-1:0] pix_data,
  input logic           pix_sof,
  input logic           pix_eof
);
  localparam int HW = $clog2(DIV_HALF + 2);
  localparam int LW = $clog2(QUIET + 2);
  localparam logic [HW-1:0] HMAX = HW'(DIV_HALF + 1);
  localparam logic [LW-1:0] LMAX = LW'(QUIET + 1);

  logic [HW-1:0] high_run;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_run <= '0;
      low_run  <= '0;
    end else begin
      if (!sen_clk)              high_run <= '0;
      else if (high_run != HMAX) high_run <= high_run + 1'b1;
      if (sen_clk)               low_run <= '0;
      else if (low_run != LMAX)  low_run <= low_run + 1'b1;
    end
  end

  p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_clk) |-> (high_run == HW'(DIV_HALF)));

  p_oe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_oe_n) |-> (low_run >= LW'(QUIET)));

  p_rst_vs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_oe_n |-> !sen_rst);

  p_rst_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rst |-> (!sen_clk && sen_oe_n));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=>
      (pix_valid && $stable(pix_data) && $stable(pix_sof) && $stable(pix_eof)));

  p_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sof || pix_eof) |-> (pix_valid && !(pix_sof && pix_eof)));
endmodule

bind swr_readout swr_readout_chk #(
  .NIB      (NIB),
  .DIV_HALF (DIV_HALF),
  .QUIET    (QUIET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sen_clk   (sen_clk),
  .sen_rst   (sen_rst),
  .sen_oe_n  (sen_oe_n),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .pix_sof   (pix_sof),
  .pix_eof   (pix_eof)
);

// File: tb/swr_readout_bench.sv
`timescale 1ns/1ps
module swr_readout_bench;
  localparam int COLS = 3;
  localparam int ROWS = 4;
  localparam int NIB  = 4;
  localparam int DH   = 2;
  localparam int QT   = 3;
  localparam int FL   = 4;
  localparam int RC   = 4;
  localparam int BPC  = ROWS / 2;
  localparam int BPF  = (COLS + 1) * BPC;
  localparam int REAL = COLS * BPC;
  localparam int PPF  = COLS * ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic pix_ready = 1'b1;
  logic [NIB-1:0] sen_even, sen_odd, pix_data;
  logic sen_clk, sen_rst, sen_oe_n, pix_valid, pix_sof, pix_eof;

  always #2 clk = ~clk;

  swr_readout #(
    .COLS(COLS), .ROWS(ROWS), .NIB(NIB), .DIV_HALF(DH),
    .QUIET(QT), .FLUSH(FL), .RST_CYC(RC)
  ) u_swr_readout (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .sen_even(sen_even), .sen_odd(sen_odd),
    .sen_clk(sen_clk), .sen_rst(sen_rst), .sen_oe_n(sen_oe_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eof(pix_eof)
  );

  function automatic logic [3:0] ev_f(int f, int j);
    return 4'((f * 5 + j * 3 + 1) % 16);
  endfunction
  function automatic logic [3:0] od_f(int f, int j);
    return 4'((f * 11 + j * 7 + 2) % 16);
  endfunction

  // sensor model: byte index counted from rising edges after the flush pulses
  int rises = 0;
  logic [3:0] s_even = '0, s_odd = '0;
  always @(posedge sen_clk or posedge sen_rst) begin
    if (sen_rst) begin
      rises = 0; s_even = '0; s_odd = '0;
    end else begin
      int b;
      rises++;
      b = rises - 1 - FL;
      if (b >= 0) begin
        s_even = ev_f(b / BPF, b % BPF);
        s_odd  = od_f(b / BPF, b % BPF);
      end
    end
  end
  assign sen_even = sen_oe_n ? 4'h0 : s_even;
  assign sen_odd  = sen_oe_n ? 4'h0 : s_odd;

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  int cyc = 0;
  bit wd = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd = 1'b1;
  end

  // monitor state
  int mode = 0;
  int exp_f = 1, exp_j = 0, frames_rx = 0, pix_cnt = 0;
  bit exp_odd = 1'b0;
  int rst_rises = 0, oe_falls = 0, rise_since_rst = 0, total_rises = 0;
  int hi_cnt = 0, low_cnt = 1000;
  bit p_clk = 1'b0, p_rst = 1'b0, p_oe = 1'b1;
  bit pend = 1'b0;
  logic [3:0] pend_d;
  bit pend_s, pend_e;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sen_rst && !p_rst) begin
        rst_rises++; exp_f = 1; exp_j = 0; exp_odd = 1'b0; pix_cnt = 0; low_cnt = 1000;
      end
      if (!sen_rst && p_rst) rise_since_rst = 0;
      if (sen_clk && !p_clk) begin
        rise_since_rst++; total_rises++;
        chk(low_cnt >= DH, "R3 low phase", low_cnt, DH);
        hi_cnt = 1;
      end else if (sen_clk) hi_cnt++;
      if (!sen_clk && p_clk) begin
        chk(hi_cnt == DH, "R3 high phase", hi_cnt, DH);
        low_cnt = 1;
      end else if (!sen_clk && low_cnt < 1000) low_cnt++;
      if (!sen_oe_n && p_oe) begin
        oe_falls++;
        chk(rise_since_rst == FL + BPF, "R2 pulses before OE", rise_since_rst, FL + BPF);
        chk(low_cnt > QT, "R4 quiet before OE", low_cnt, QT + 1);
      end
      if (!sen_oe_n && sen_rst) chk(1'b0, "R4 reset while enabled", 1, 0);
      if (pend)
        chk(pix_valid && pix_data == pend_d && pix_sof == pend_s && pix_eof == pend_e,
            "R8 hold under stall", int'(pix_data), int'(pend_d));
      // drive ready for the coming edge, then judge the handshake with it
      case (mode)
        0: pix_ready = 1'b1;
        1: pix_ready = (cyc % 2) == 0;
        2: pix_ready = (cyc % 5) == 0;
        default: pix_ready = (cyc % 38) >= 30;
      endcase
      if (pix_valid && pix_ready) begin
        logic [3:0] e_d;
        bit e_s, e_e;
        e_d = exp_odd ? od_f(exp_f, exp_j) : ev_f(exp_f, exp_j);
        e_s = (exp_j == 0) && !exp_odd;
        e_e = (exp_j == REAL - 1) && exp_odd;
        chk(pix_data == e_d, "R5 pixel value", int'(pix_data), int'(e_d));
        chk(pix_sof == e_s && pix_eof == e_e, "R7 frame marks",
            int'({pix_sof, pix_eof}), int'({e_s, e_e}));
        pix_cnt++;
        if (e_e) begin
          chk(pix_cnt == PPF, "R6 pixels per frame", pix_cnt, PPF);
          pix_cnt = 0; frames_rx++; exp_f++; exp_j = 0; exp_odd = 1'b0;
          mode = frames_rx % 4;
        end else if (exp_odd) begin
          exp_odd = 1'b0; exp_j++;
        end else exp_odd = 1'b1;
      end
      pend = pix_valid && !pix_ready;
      pend_d = pix_data; pend_s = pix_sof; pend_e = pix_eof;
      p_clk = sen_clk; p_rst = sen_rst; p_oe = sen_oe_n;
    end
  end

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    int at, tr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sen_rst == 1'b0, "R1 reset low", int'(sen_rst), 0);
    chk(sen_oe_n == 1'b1, "R1 OE high", int'(sen_oe_n), 1);
    chk(sen_clk == 1'b0, "R1 clock low", int'(sen_clk), 0);
    chk(pix_valid == 1'b0, "R1 no valid", int'(pix_valid), 0);

    // stop in idle has no effect
    pulse_stop();
    repeat (20) @(negedge clk);
    chk(total_rises == 0 && rst_rises == 0, "R10 idle stop ignored", total_rises, 0);

    // session 1: start, run through all ready patterns
    pulse_start();
    while (frames_rx < 3 && !wd) @(negedge clk);
    pulse_start();  // ignored while running
    while (frames_rx < 8 && !wd) @(negedge clk);
    chk(rst_rises == 1, "R9 no reset between frames", rst_rises, 1);
    chk(oe_falls == 1, "R9 single OE assertion", oe_falls, 1);

    // stop mid-frame
    while (!(exp_j == 2) && !wd) @(negedge clk);
    at = frames_rx;
    pulse_stop();
    while (!sen_oe_n && !wd) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(frames_rx - at == 1, "R10 frame in progress completes", frames_rx - at, 1);
    chk(exp_j == 0 && !exp_odd, "R10 stops at frame boundary", exp_j, 0);
    tr = total_rises;
    repeat (50) @(negedge clk);
    chk(total_rises == tr, "R10 no clock in idle", total_rises - tr, 0);
    chk(!sen_rst && sen_oe_n && !pix_valid, "R10 idle pins",
        int'({sen_rst, sen_oe_n, pix_valid}), 3'b010);

    // session 2: restart runs the full sequence again
    at = frames_rx;
    pulse_start();
    while (frames_rx < at + 2 && !wd) @(negedge clk);
    chk(rst_rises == 2, "R2 restart pulses reset", rst_rises, 2);
    pulse_stop();
    while (!sen_oe_n && !wd) @(negedge clk);
    repeat (10) @(negedge clk);

    // session 3: stop during start-up ends after the discarded frame
    at = frames_rx; tr = oe_falls;
    pulse_start();
    while (!sen_rst && !wd) @(negedge clk);
    while (sen_rst && !wd) @(negedge clk);
    pulse_stop();
    repeat (FL * 2 * DH + BPF * 2 * DH + 40) @(negedge clk);
    chk(rise_since_rst == FL + BPF, "R10 start-up stop pulse count", rise_since_rst, FL + BPF);
    chk(oe_falls == tr, "R10 OE never asserted", oe_falls - tr, 0);
    chk(frames_rx == at && !pix_valid, "R10 no pixels", frames_rx - at, 0);

    if (wd) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule